// File: doc/BRIEF.md
# Bus Hold Arbiter with Interrupt Request

This block lends a microcontroller's external bus to an outside master and hands it back again. The outside master asks for the bus by pulling an active-low hold request low. The block passes that request through a synchronizer. It waits for the current bus cycle to finish and then answers with an active-low hold acknowledge. While acknowledge is low the CPU stays off the bus. A control bit gates the whole protocol: when the bit is clear, the hold request has no effect.

While the bus is lent out, an interrupt may become pending that needs the bus. The block tells the outside master about it in one of three ways, chosen by where code runs and when the interrupt arrives:
- When code runs from internal memory, the active-low interrupt output drops at once.
- When code runs from external memory, the active-low bus request drops first. The interrupt output follows only after the master has withdrawn its hold request.
- When code runs from external memory and the interrupt arrives while the block is still waiting to grant, acknowledge and the interrupt output drop on the same edge.

Both indications clear once the CPU owns the bus again and the pending-interrupt input is low.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released, `hold_ack_n`, `bus_req_n` and `irq_out_n` are all high and the controller is idle. Asserting `rst_n` drives all three high without waiting for a clock.
- R2: While `hold_en` is 0, a low `hold_req_n` is ignored and `hold_ack_n` stays high.
- R3: With `hold_en`=1 and `cycle_done`=1, `hold_ack_n` goes low on the 4th rising edge after `hold_req_n` falls: 2 synchronizer edges, 1 edge into the entering state and 1 edge into the held state.
- R4: `hold_ack_n` falls only on an edge where `cycle_done` was 1. While `cycle_done` stays 0, the grant waits.
- R5: Case: held, `exec_ext`=0, `irq_pend`=1. Then `irq_out_n` goes low one edge later and `bus_req_n` stays high.
- R6: Case: held, `exec_ext`=1, `irq_pend`=1. Then `bus_req_n` goes low one edge later. `irq_out_n` stays high while the bus is held and goes low only after `hold_ack_n` has returned high.
- R7: Case: `exec_ext`=1, a request is being granted, and `irq_pend` becomes 1 before the grant. Then `hold_ack_n` and `irq_out_n` fall on the same edge. `irq_out_n` stays low for as long as the hold request stays low, even if `irq_pend` drops.
- R8: `bus_req_n` and `irq_out_n` return high only once the CPU owns the bus (`hold_ack_n` high) and `irq_pend` is 0. They stay low while `irq_pend` stays 1.
- R9: `hold_ack_n` returns high on the 3rd rising edge after `hold_req_n` rises. A request withdrawn before `cycle_done` returns the controller to idle without any acknowledge.
- R10: Clearing `hold_en` while the bus is held returns the bus, as if the request had been withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hold_req_n | input | 1 | Active-low bus hold request from the external master (asynchronous) |
| hold_en | input | 1 | Hold protocol enable (control bit) |
| irq_pend | input | 1 | High while an interrupt that needs the bus is pending |
| exec_ext | input | 1 | 1 = code runs from external memory, 0 = internal memory |
| cycle_done | input | 1 | High when the current bus cycle ends this clock |
| hold_ack_n | output | 1 | Active-low hold acknowledge: bus released to the external master |
| bus_req_n | output | 1 | Active-low request to get the bus back |
| irq_out_n | output | 1 | Active-low interrupt output |

## Verification
The assertions check on every cycle that:
- an acknowledge edge always follows a finished bus cycle with the enable set;
- the bus request only drops while held and with code running externally;
- in the external case, the interrupt output drops only after acknowledge has returned high;
- both indications clear only once the bus is back and the pending input is low.

Only the bench scenarios can show:
- the exact synchronizer latency on grant and release;
- the same-edge grant and interrupt in the entering-hold case, kept until hold is withdrawn;
- an aborted request that never acknowledges;
- release on a cleared enable;
- the asynchronous effect of reset.

// File: rtl/bha_pkg.sv
package bha_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ENTERING = 2'd1,
    ST_HELD     = 2'd2,
    ST_RELEASE  = 2'd3
  } hold_state_t;

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i <= LAST; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[LAST];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bha_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        cycle_done,
  output hold_state_t state
);
  hold_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req) state_d = ST_ENTERING;
      ST_ENTERING: begin
        if (!req)            state_d = ST_IDLE;
        else if (cycle_done) state_d = ST_HELD;
      end
      ST_HELD:     if (!req) state_d = ST_RELEASE;
      ST_RELEASE:  state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/bha_irq.sv
module bha_irq
  import bha_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  hold_state_t state,
  input  logic        req,
  input  logic        cycle_done,
  input  logic        irq_pend,
  input  logic        exec_ext,
  output logic        breq,
  output logic        irq
);
  logic entry_q, entry_d, entry_en;
  logic breq_q, breq_d, breq_en;
  logic irq_q, irq_d, irq_en;

  logic in_idle, in_enter, in_held, in_rel;
  logic cpu_free;
  logic grant_now;

  assign in_idle  = (state == ST_IDLE);
  assign in_enter = (state == ST_ENTERING);
  assign in_held  = (state == ST_HELD);
  assign in_rel   = (state == ST_RELEASE);
  assign cpu_free = in_idle && !irq_pend;
  assign grant_now = in_enter && req && cycle_done;

  // entry flag: interrupt seen while entering hold with external code
  always_comb begin
    entry_en = 1'b0;
    entry_d  = entry_q;
    if (in_idle) begin
      entry_en = 1'b1;
      entry_d  = 1'b0;
    end else if (in_enter && irq_pend && exec_ext) begin
      entry_en = 1'b1;
      entry_d  = 1'b1;
    end
  end

  // bus request: held, external code, interrupt pending
  always_comb begin
    breq_en = 1'b0;
    breq_d  = breq_q;
    if (cpu_free) begin
      breq_en = 1'b1;
      breq_d  = 1'b0;
    end else if (in_held && irq_pend && exec_ext && !irq_q) begin
      breq_en = 1'b1;
      breq_d  = 1'b1;
    end
  end

  // interrupt output: three set paths, one clear path
  always_comb begin
    irq_en = 1'b0;
    irq_d  = irq_q;
    if (cpu_free) begin
      irq_en = 1'b1;
      irq_d  = 1'b0;
    end else if (grant_now && exec_ext && (entry_q || irq_pend)) begin
      irq_en = 1'b1;
      irq_d  = 1'b1;
    end else if (in_held && irq_pend && !exec_ext && !breq_q) begin
      irq_en = 1'b1;
      irq_d  = 1'b1;
    end else if (in_rel && breq_q) begin
      irq_en = 1'b1;
      irq_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= 1'b0;
      breq_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (entry_en) entry_q <= entry_d;
      if (breq_en)  breq_q  <= breq_d;
      if (irq_en)   irq_q   <= irq_d;
    end
  end

  assign breq = breq_q;
  assign irq  = irq_q;
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req_n,
  input  logic hold_en,
  input  logic irq_pend,
  input  logic exec_ext,
  input  logic cycle_done,
  output logic hold_ack_n,
  output logic bus_req_n,
  output logic irq_out_n
);
  logic        rst_int_n;
  logic        hreq_n_s;
  logic        req;
  hold_state_t state;
  logic        breq;
  logic        irq;

  bha_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  bha_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (hold_req_n),
    .q     (hreq_n_s)
  );

  assign req = hold_en && !hreq_n_s;

  bha_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req        (req),
    .cycle_done (cycle_done),
    .state      (state)
  );

  bha_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .state      (state),
    .req        (req),
    .cycle_done (cycle_done),
    .irq_pend   (irq_pend),
    .exec_ext   (exec_ext),
    .breq       (breq),
    .irq        (irq)
  );

  assign hold_ack_n = (state != ST_HELD);
  assign bus_req_n  = !breq;
  assign irq_out_n  = !irq;
endmodule

// File: rtl/bha_checker.sv
module bha_checker (
  input logic clk,
  input logic rst_n,
  input logic hold_en,
  input logic irq_pend,
  input logic exec_ext,
  input logic cycle_done,
  input logic hold_ack_n,
  input logic bus_req_n,
  input logic irq_out_n
);
  p_grant_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(hold_en));

  p_grant_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> $past(cycle_done));

  p_breq_external_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_n) |-> ($past(exec_ext) && !$past(hold_ack_n)));

  p_irq_after_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_out_n) && !bus_req_n) |-> hold_ack_n);

  p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out_n) |-> (hold_ack_n && !$past(irq_pend)));

  p_breq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_n) |-> (hold_ack_n && !$past(irq_pend)));
endmodule

bind bus_hold_arbiter bha_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_en    (hold_en),
  .irq_pend   (irq_pend),
  .exec_ext   (exec_ext),
  .cycle_done (cycle_done),
  .hold_ack_n (hold_ack_n),
  .bus_req_n  (bus_req_n),
  .irq_out_n  (irq_out_n)
);

// File: tb/sim_bus_hold_arbiter.sv
`timescale 1ns/1ps
module sim_bus_hold_arbiter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE     = 5;
  localparam int  WDOG_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n, hold_req_n, hold_en, irq_pend, exec_ext, cycle_done;
  logic hold_ack_n, bus_req_n, irq_out_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .hold_en(hold_en),
    .irq_pend(irq_pend), .exec_ext(exec_ext), .cycle_done(cycle_done),
    .hold_ack_n(hold_ack_n), .bus_req_n(bus_req_n), .irq_out_n(irq_out_n)
  );

  typedef struct packed {
    logic req_n, en, pend, ext, done;
    logic ack, breq, irq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R1 idle
    '{1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R2 disabled request ignored
    '{1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1}, // R4 waits for cycle end
    '{1'b0,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b1}, // R3 granted
    '{1'b0,1'b1,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b0}, // R5 internal: irq at once
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0}, // R8 kept while pending
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1}, // R8 cleared
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b1}, // R3 granted, external code
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1}, // R6 bus request only
    '{1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0}, // R6 irq after release
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}, // R8 both cleared
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R4 entering, no grant
    '{1'b0,1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1}, // R7 irq while entering
    '{1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0}, // R7 ack with irq
    '{1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0}, // R7 kept until hold drops
    '{1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1}  // R8 all clear
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk3(input string tag, input logic ea, input logic eb, input logic ei);
    chk({tag, " hold_ack_n"}, hold_ack_n, ea);
    chk({tag, " bus_req_n"},  bus_req_n,  eb);
    chk({tag, " irq_out_n"},  irq_out_n,  ei);
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; hold_req_n = 1'b1; hold_en = 1'b1;
    irq_pend = 1'b0; exec_ext = 1'b0; cycle_done = 1'b1;
    edges(3);
    chk3("R1 in reset", 1'b1, 1'b1, 1'b1);
    rst_n = 1'b1;
    edges(SETTLE);
    chk3("R1 after reset", 1'b1, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      hold_req_n = VECS[i].req_n;
      hold_en    = VECS[i].en;
      irq_pend   = VECS[i].pend;
      exec_ext   = VECS[i].ext;
      cycle_done = VECS[i].done;
      edges(SETTLE);
      chk3($sformatf("vector %0d", i), VECS[i].ack, VECS[i].breq, VECS[i].irq);
    end

    // R3 grant latency
    exec_ext = 1'b0; cycle_done = 1'b1; hold_req_n = 1'b0;
    edges(3);
    chk("R3 ack not yet after 3 edges", hold_ack_n, 1'b1);
    edges(1);
    chk("R3 ack on 4th edge", hold_ack_n, 1'b0);

    // R9 release latency
    hold_req_n = 1'b1;
    edges(2);
    chk("R9 ack still low after 2 edges", hold_ack_n, 1'b0);
    edges(1);
    chk("R9 ack high on 3rd edge", hold_ack_n, 1'b1);
    edges(SETTLE);

    // R9 withdrawn before the bus cycle ends
    cycle_done = 1'b0; hold_req_n = 1'b0;
    edges(SETTLE);
    hold_req_n = 1'b1;
    edges(SETTLE);
    cycle_done = 1'b1;
    edges(SETTLE);
    chk("R9 aborted request never acknowledged", hold_ack_n, 1'b1);

    // R10 enable cleared while held
    hold_req_n = 1'b0;
    edges(SETTLE);
    chk("R10 held before enable drop", hold_ack_n, 1'b0);
    hold_en = 1'b0;
    edges(SETTLE);
    chk("R10 bus returned after enable drop", hold_ack_n, 1'b1);
    hold_en = 1'b1; hold_req_n = 1'b1;
    edges(SETTLE);

    // R1 reset while held, with interrupt shown
    hold_req_n = 1'b0; irq_pend = 1'b1;
    edges(SETTLE);
    chk3("R1 held before reset", 1'b0, 1'b1, 1'b0);
    #1 rst_n = 1'b0;
    #1 chk3("R1 async reset", 1'b1, 1'b1, 1'b1);
    hold_req_n = 1'b1; irq_pend = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(SETTLE);
    chk3("R1 idle after reset", 1'b1, 1'b1, 1'b1);

    finish_run();
  end
endmodule